// File: doc/BRIEF.md
# Edge-Sensitive Interrupt Port

This block serves eight general-purpose pins as interrupt sources for an interrupt controller. Software programs it through a small byte/halfword register bus. A two-bit sense field for each pin selects one of four conditions: a low level, a rising edge, a falling edge, or either edge. Pad inputs are resynchronized before any decision is made. Edge events are held in sticky flags until software clears them by writing ones. The block drives one request line per pin, gated by a per-pin enable.

The block also holds an output value register and a drive-direction register for the pads. It offers a read-only view of the synchronized pad levels. Pin 0 is reserved. All of its register bits read as zero, it never sets a flag, and it never raises a request. Address decoding above the 3-bit offset, the pad buffers and glitch filtering lie outside this block.

Top module: `eport_top`

## Requirements
- R1: After reset, the sense, direction, enable, output-value and stored-flag registers read zero, and every request output is low.
- R2: Register offsets are fixed. Halfword accesses use even offsets and are big-endian (the even offset is bits [15:8]). Byte accesses use bits [7:0]. The offsets are:
  - 0: sense halfword, pin n at bits [2n+1:2n];
  - 2: direction, which drives `padOe`;
  - 3: enable;
  - 4: output value, which drives `padOut`;
  - 5: pin view;
  - 6: flags;
  - 7: always reads zero.
- R3: Offset 5 returns the pad inputs after a two-flop synchronizer. A change is visible after the second rising clock edge, and writes to offset 5 are ignored.
- R4: Sense code 2'b01 latches a flag on a rising edge, 2'b10 on a falling edge and 2'b11 on either edge. The flag is readable after the third rising clock edge that follows the pad change.
- R5: Sense code 2'b00 is level mode. The flag bit reads as the inverted synchronized pad level and is never latched, so flag-clear writes do not affect it. Switching a pin to level mode discards any latched flag.
- R6: In edge modes a flag stays set until a one is written to its bit at offset 6. Writing zero bits leaves the flags unchanged.
- R7: A detected edge sets its flag whether or not the pin is enabled. Each request output is the pin's flag bit ANDed with its enable bit.
- R8: When a clear write and a new edge on the same pin fall in the same cycle, the flag remains set.
- R9: Pin 0 is reserved. Its bits read zero in every register, including sense bits [1:0], and it never sets a flag or a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWr | input | 1 | Write strobe, applied on the rising edge |
| busSize | input | 1 | 0 = byte access, 1 = halfword access |
| busAddr | input | 3 | Byte offset |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data, combinational from busSize and busAddr |
| padIn | input | 8 | Pad input levels |
| padOut | output | 8 | Output value register |
| padOe | output | 8 | Direction register; 1 = drive pad |
| irqReq | output | 8 | Per-pin interrupt requests |

## Verification
The bench builds the block with its defaults: eight pins and a two-stage synchronizer. With these values the exact three-edge latency from pad change to flag, and the two-edge latency to the pin view, can be checked cycle by cycle. The small pin count also lets random stimulus hit every sense code on every pin, together with mode changes, overlapping clear writes and enable changes. Directed cases cover the reserved pin, the ignored write to the pin view, and a clear that arrives in the same cycle as an edge.

// File: rtl/eport_pkg.sv
package eport_pkg;
  localparam int PINS    = 8;
  localparam int PA_W    = 2 * PINS;
  localparam int ADDR_W  = 3;
  localparam int BUS_W   = 16;
  localparam int BYTE_W  = 8;

  typedef enum logic [1:0] {
    SENSE_LEVEL = 2'b00,
    SENSE_RISE  = 2'b01,
    SENSE_FALL  = 2'b10,
    SENSE_BOTH  = 2'b11
  } sense_e;

  typedef struct packed {
    logic              wrPaHi;
    logic              wrPaLo;
    logic              wrDir;
    logic              wrEn;
    logic              wrData;
    logic              wrFlag;
    logic [BYTE_W-1:0] evenByte;
    logic [BYTE_W-1:0] oddByte;
  } strobe_t;
endpackage

// File: rtl/eport_sync.sv
module eport_sync #(
  parameter int               WIDTH   = 8,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) stage[s] <= RST_VAL;
    end else begin
      stage[0] <= d;
      for (int s = 1; s < STAGES; s++) stage[s] <= stage[s-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/eport_ctrl.sv
module eport_ctrl
  import eport_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busSize,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BUS_W-1:0]  busWdata,
  input  logic [PA_W-1:0]   paReg,
  input  logic [PINS-1:0]   dirReg,
  input  logic [PINS-1:0]   enReg,
  input  logic [PINS-1:0]   dataReg,
  input  logic [PINS-1:0]   pinView,
  input  logic [PINS-1:0]   flagView,
  output strobe_t           strb,
  output logic [BUS_W-1:0]  busRdata
);
  localparam int PAIR_W = ADDR_W - 1;

  logic              evenHit, oddHit;
  logic [PAIR_W-1:0] pairIdx;
  logic [BYTE_W-1:0] byteVec [2**ADDR_W];

  assign pairIdx = busAddr[ADDR_W-1:1];
  assign evenHit = busSize | ~busAddr[0];
  assign oddHit  = busSize |  busAddr[0];

  always_comb begin
    strb          = '0;
    strb.evenByte = busSize ? busWdata[15:8] : busWdata[7:0];
    strb.oddByte  = busWdata[7:0];
    strb.wrPaHi   = busWr & evenHit & (pairIdx == 2'd0);
    strb.wrPaLo   = busWr & oddHit  & (pairIdx == 2'd0);
    strb.wrDir    = busWr & evenHit & (pairIdx == 2'd1);
    strb.wrEn     = busWr & oddHit  & (pairIdx == 2'd1);
    strb.wrData   = busWr & evenHit & (pairIdx == 2'd2);
    strb.wrFlag   = busWr & evenHit & (pairIdx == 2'd3);
  end

  always_comb begin
    byteVec[0] = paReg[15:8];
    byteVec[1] = paReg[7:0];
    byteVec[2] = dirReg;
    byteVec[3] = enReg;
    byteVec[4] = dataReg;
    byteVec[5] = pinView;
    byteVec[6] = flagView;
    byteVec[7] = '0;
  end

  assign busRdata = busSize ? {byteVec[{pairIdx, 1'b0}], byteVec[{pairIdx, 1'b1}]}
                            : {8'h00, byteVec[busAddr]};

  // R2: a single access touches at most one lane pair
  p_lane_pair_r2: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strb.wrPaHi, strb.wrPaLo, strb.wrDir, strb.wrEn, strb.wrData, strb.wrFlag}) <= 2);

  // R2: a byte access never fires more than one register strobe
  p_byte_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    !busSize |-> $onehot0({strb.wrPaHi, strb.wrPaLo, strb.wrDir, strb.wrEn, strb.wrData, strb.wrFlag}));
endmodule

// File: rtl/eport_datapath.sv
module eport_datapath
  import eport_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         strb,
  input  logic [PINS-1:0] padIn,
  output logic [PA_W-1:0] paReg,
  output logic [PINS-1:0] dirReg,
  output logic [PINS-1:0] enReg,
  output logic [PINS-1:0] dataReg,
  output logic [PINS-1:0] pinView,
  output logic [PINS-1:0] flagView,
  output logic [PINS-1:0] irqReq
);
  localparam logic [PINS-1:0] USE_MASK = {{(PINS-1){1'b1}}, 1'b0};
  localparam logic [PA_W-1:0] PA_MASK  = {{(PA_W-2){1'b1}}, 2'b00};

  logic [PINS-1:0] syncPin, prevPin;
  logic [PINS-1:0] flagReg, flagNext;
  logic [PINS-1:0] levelMask, edgeHit, clearMask;

  eport_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk (clk),
    .rstN(rstN),
    .d   (padIn),
    .q   (syncPin)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevPin <= '1;
    else       prevPin <= syncPin;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      paReg   <= '0;
      dirReg  <= '0;
      enReg   <= '0;
      dataReg <= '0;
    end else begin
      if (strb.wrPaHi) paReg[15:8] <= strb.evenByte & PA_MASK[15:8];
      if (strb.wrPaLo) paReg[7:0]  <= strb.oddByte  & PA_MASK[7:0];
      if (strb.wrDir)  dirReg      <= strb.evenByte & USE_MASK;
      if (strb.wrEn)   enReg       <= strb.oddByte  & USE_MASK;
      if (strb.wrData) dataReg     <= strb.evenByte & USE_MASK;
    end
  end

  assign clearMask = strb.wrFlag ? strb.evenByte : '0;

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    sense_e mode;
    logic   rise, fall, hit;

    assign mode = sense_e'(paReg[2*i +: 2]);
    assign rise = syncPin[i] & ~prevPin[i];
    assign fall = ~syncPin[i] & prevPin[i];

    always_comb begin
      case (mode)
        SENSE_RISE: hit = rise;
        SENSE_FALL: hit = fall;
        SENSE_BOTH: hit = rise | fall;
        default:    hit = 1'b0;
      endcase
    end

    assign levelMask[i] = (mode == SENSE_LEVEL);
    assign edgeHit[i]   = hit & USE_MASK[i];
    assign flagNext[i]  = levelMask[i] ? 1'b0 :
                          edgeHit[i]   ? 1'b1 :
                          clearMask[i] ? 1'b0 : flagReg[i];
    assign flagView[i]  = USE_MASK[i] & (levelMask[i] ? ~syncPin[i] : flagReg[i]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagReg <= '0;
    else       flagReg <= flagNext;
  end

  assign pinView = syncPin & USE_MASK;
  assign irqReq  = flagView & enReg;

  // R9: reserved pin stays silent everywhere
  p_pin0_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq[0] == 1'b0) && (flagView[0] == 1'b0) && (paReg[1:0] == 2'b00));

  // R6: a latched flag survives unless cleared or moved to level mode
  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    (($past(flagReg & ~clearMask & ~levelMask) & ~levelMask & ~flagReg) == '0));

  // R8: a detected edge always leaves its flag set, clear or not
  p_edge_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
    (($past(edgeHit) & ~levelMask & ~flagReg) == '0));

  // R5: level mode never leaves a stored flag behind
  p_level_unlatched_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((flagReg & $past(levelMask)) == '0));

  // R2: direction changes only through its own write
  p_dir_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.wrDir) |-> $stable(dirReg));
endmodule

// File: rtl/eport_top.sv
module eport_top
  import eport_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busSize,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BUS_W-1:0]  busWdata,
  output logic [BUS_W-1:0]  busRdata,
  input  logic [PINS-1:0]   padIn,
  output logic [PINS-1:0]   padOut,
  output logic [PINS-1:0]   padOe,
  output logic [PINS-1:0]   irqReq
);
  strobe_t         strb;
  logic [PA_W-1:0] paReg;
  logic [PINS-1:0] dirReg, enReg, dataReg, pinView, flagView;

  eport_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busWr   (busWr),
    .busSize (busSize),
    .busAddr (busAddr),
    .busWdata(busWdata),
    .paReg   (paReg),
    .dirReg  (dirReg),
    .enReg   (enReg),
    .dataReg (dataReg),
    .pinView (pinView),
    .flagView(flagView),
    .strb    (strb),
    .busRdata(busRdata)
  );

  eport_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .padIn   (padIn),
    .paReg   (paReg),
    .dirReg  (dirReg),
    .enReg   (enReg),
    .dataReg (dataReg),
    .pinView (pinView),
    .flagView(flagView),
    .irqReq  (irqReq)
  );

  assign padOut = dataReg;
  assign padOe  = dirReg;
endmodule

// File: tb/eport_top_tb.sv
module eport_top_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0;
  logic        busSize = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic [7:0]  padIn = 8'hFF;
  logic [7:0]  padOut, padOe, irqReq;

  int checks = 0;
  int errors = 0;

  eport_top u_dut (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busSize(busSize), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .padIn(padIn), .padOut(padOut),
    .padOe(padOe), .irqReq(irqReq)
  );

  always #5 clk = ~clk;

  // Reference model built from the requirements
  logic [15:0] mPa;
  logic [7:0]  mEn, mFlag, mS1, mS2, mPrev;

  function automatic logic [8:0] laneFor(int off);
    logic hit;
    logic [7:0] val;
    hit = busWr && (busSize ? ((off >> 1) == int'(busAddr[2:1])) : (off == int'(busAddr)));
    val = (busSize && (off % 2 == 0)) ? busWdata[15:8] : busWdata[7:0];
    return {hit, val};
  endfunction

  function automatic logic [7:0] flagNextModel();
    logic [7:0] nxt;
    logic [8:0] clr;
    clr = laneFor(6);
    nxt = mFlag;
    for (int i = 1; i < 8; i++) begin
      logic [1:0] md;
      logic r, f, h;
      md = mPa[2*i +: 2];
      r = mS2[i] & ~mPrev[i];
      f = ~mS2[i] & mPrev[i];
      h = (md == 2'b01) ? r : (md == 2'b10) ? f : (md == 2'b11) ? (r | f) : 1'b0;
      if (md == 2'b00)      nxt[i] = 1'b0;
      else if (h)           nxt[i] = 1'b1;
      else if (clr[8] && clr[i]) nxt[i] = 1'b0;
    end
    nxt[0] = 1'b0;
    return nxt;
  endfunction

  function automatic logic [7:0] flagViewModel();
    logic [7:0] v;
    v = '0;
    for (int i = 1; i < 8; i++)
      v[i] = (mPa[2*i +: 2] == 2'b00) ? ~mS2[i] : mFlag[i];
    return v;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPa <= '0; mEn <= '0; mFlag <= '0;
      mS1 <= 8'hFF; mS2 <= 8'hFF; mPrev <= 8'hFF;
    end else begin
      logic [8:0] l0, l1, l3;
      l0 = laneFor(0); l1 = laneFor(1); l3 = laneFor(3);
      mS1 <= padIn; mS2 <= mS1; mPrev <= mS2;
      mFlag <= flagNextModel();
      if (l0[8]) mPa[15:8] <= l0[7:0];
      if (l1[8]) mPa[7:0]  <= l1[7:0] & 8'hFC;
      if (l3[8]) mEn       <= l3[7:0] & 8'hFE;
    end
  end

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  // All bus actions start just after a falling edge
  task automatic wr(logic sz, logic [2:0] a, logic [15:0] d);
    busSize = sz; busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(logic sz, logic [2:0] a, output logic [15:0] d);
    busSize = sz; busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'd20240));
    cyc(3);
    rstN = 1'b1;
    cyc(3);

    // R1 reset state
    rd(1, 0, v); chk("R1 sense", v, 16'h0000);
    rd(1, 2, v); chk("R1 dir/en", v, 16'h0000);
    rd(1, 4, v); chk("R1 data/pin", v, 16'h00FE);
    rd(0, 6, v); chk("R1 flag", v, 16'h0000);
    chk("R1 irq", {8'h0, irqReq}, 16'h0000);

    // R3 pin view latency and read-only; R5 level view
    wr(0, 5, 16'h0000);
    rd(0, 5, v); chk("R3 write ignored", v, 16'h00FE);
    padIn = 8'hF0;
    cyc(1); rd(0, 5, v); chk("R3 one edge", v, 16'h00FE);
    cyc(1); rd(0, 5, v); chk("R3 two edges", v, 16'h00F0);
    rd(0, 6, v); chk("R5 level view", v, 16'h000E);
    wr(0, 6, 16'h00FF);
    rd(0, 6, v); chk("R5 clear ignored", v, 16'h000E);
    padIn = 8'hFF; cyc(4);
    rd(0, 6, v); chk("R5 released", v, 16'h0000);

    // R2 map and pads
    wr(0, 2, 16'h00A5); chk("R2 padOe", {8'h0, padOe}, 16'h00A4);
    wr(0, 4, 16'h003C); chk("R2 padOut", {8'h0, padOut}, 16'h003C);
    wr(1, 2, 16'h1234);
    rd(1, 2, v); chk("R2 half dir/en", v, 16'h1234);
    rd(0, 3, v); chk("R2 byte en", v, 16'h0034);
    rd(0, 7, v); chk("R2 byte7", v, 16'h0000);
    wr(1, 2, 16'h0000);

    // R9 reserved sense bits
    wr(1, 0, 16'hFFFF);
    rd(1, 0, v); chk("R9 sense bits", v, 16'hFFFC);

    // R4 falling edge on pin 1 with latency; R7 without enable
    wr(1, 0, 16'h0008);
    cyc(2);
    padIn[1] = 1'b0;
    cyc(2); rd(0, 6, v); chk("R4 not yet", v, 16'h0000);
    cyc(1); rd(0, 6, v); chk("R4 fall flag", v, 16'h0002);
    chk("R7 no enable", {8'h0, irqReq}, 16'h0000);
    wr(0, 3, 16'h0002);
    chk("R7 enabled irq", {8'h0, irqReq}, 16'h0002);
    wr(0, 6, 16'h0000);
    rd(0, 6, v); chk("R6 zeros keep", v, 16'h0002);
    padIn[1] = 1'b1; cyc(4);
    rd(0, 6, v); chk("R6 sticky", v, 16'h0002);
    wr(0, 6, 16'h0002);
    rd(0, 6, v); chk("R6 cleared", v, 16'h0000);
    chk("R7 irq drop", {8'h0, irqReq}, 16'h0000);

    // R8 clear and new edge in the same cycle (both-edge mode)
    wr(1, 0, 16'h000C);
    padIn[1] = 1'b0; cyc(4);
    rd(0, 6, v); chk("R4 both fall", v, 16'h0002);
    padIn[1] = 1'b1;
    cyc(2);
    wr(0, 6, 16'h0002);
    rd(0, 6, v); chk("R8 edge wins", v, 16'h0002);
    wr(0, 6, 16'h0002);
    rd(0, 6, v); chk("R8 later clear", v, 16'h0000);

    // R4 rising on pin 3, then R5 drop on switch to level
    wr(1, 0, 16'h0040);
    padIn[3] = 1'b0; cyc(4);
    rd(0, 6, v); chk("R4 no rise yet", v, 16'h0000);
    padIn[3] = 1'b1; cyc(4);
    rd(0, 6, v); chk("R4 rise flag", v, 16'h0008);
    wr(1, 0, 16'h0000);
    rd(0, 6, v); chk("R5 latched dropped", v, 16'h0000);

    // R9 pin 0 toggling
    wr(0, 3, 16'h00FF);
    wr(1, 0, 16'hFFFF);
    padIn[0] = 1'b0; cyc(4); padIn[0] = 1'b1; cyc(4);
    rd(0, 6, v); chk("R9 pin0 flag", v, 16'h0000);
    chk("R9 pin0 irq", {15'h0, irqReq[0]}, 16'h0000);
    rd(0, 3, v); chk("R9 pin0 enable", v, 16'h00FE);

    // Random phase against the model: R4 R5 R6 R7 R8
    for (int it = 0; it < 4000; it++) begin
      int act;
      rd(0, 6, v);
      chk("R4/R6 random flag", v, {8'h0, flagViewModel()});
      chk("R7 random irq", {8'h0, irqReq}, {8'h0, flagViewModel() & mEn});
      if ($urandom % 2 == 0) padIn = padIn ^ 8'($urandom);
      act = int'($urandom % 10);
      busWr = 1'b0;
      case (act)
        0: begin busSize = 1; busAddr = 0; busWdata = 16'($urandom); busWr = 1; end
        1: begin busSize = 0; busAddr = 3; busWdata = 16'($urandom); busWr = 1; end
        2, 3: begin busSize = 0; busAddr = 6; busWdata = 16'($urandom); busWr = 1; end
        default: ;
      endcase
      @(negedge clk);
      busWr = 1'b0;
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule